// File: doc/BRIEF.md
# Device Interrupt Router

This block routes interrupts from a fixed set of device sources to processors. For each source it keeps a routing entry and a control entry. The routing entry holds a destination CPU number and a vector. The control entry holds a mask bit and a pending flag. Software reads and writes both entries through a small memory-mapped register port.

A device signals by driving its bit of `dev_irq` high. If that source is unmasked, the request is accepted. Only one request is accepted per cycle, and the lowest-numbered source wins. Accepting a request does three things:
- it marks the source pending,
- it masks the source again,
- it issues a single-cycle post carrying the routed CPU and vector.

Because the source is re-masked on acceptance, software must unmask it before that source can interrupt again. Requests that lose arbitration stay queued inside the block and are served in later cycles.

Top module: `irq_router`

## Requirements
- R1: After reset every source is masked, not pending, and routed to CPU 0 with vector 0. `post_valid`, `bus_err` and `bus_rdata` are 0.
- R2: Routing entry i is at offset `0x000 + 8*i`.
  - A write stores `wdata[12:8]` as the CPU and `wdata[5:0]` as the vector.
  - A read returns them in the same bit positions, with all other bits 0.
- R3: Control entry i is at offset `0x400 + 8*i`.
  - Bit 2 is the mask; it can be read and written.
  - Bit 0 reads back the pending flag.
  - All other read bits are 0.
- R4: Writing a control entry with bit 1 set clears pending. Writing it with bit 1 clear leaves pending unchanged.
- R5: A `dev_irq` bit that arrives while its source is masked is dropped. No post is issued and no state changes.
- R6: An accepted request produces `post_valid` for exactly one cycle, in the cycle after the clock edge that samples it.
  - The post carries the source's current CPU and vector.
  - The source is then masked and pending.
- R7: When several unmasked sources request in the same cycle, one post is issued per cycle, in ascending source order. Queued requests are never lost.
- R8: An access outside the mapped entries, or with `addr[2:0]` not zero, has these effects:
  - a read returns 0;
  - a write changes nothing;
  - `bus_err` is high for one cycle, in the cycle after the access.
- R9: When a request is accepted in the same cycle as a software write to that source's control entry, acceptance takes effect. The source ends masked and pending, even if the write cleared pending or cleared the mask.
- R10: Read data appears on `bus_rdata` in the cycle after the access. `bus_rdata` is 0 in any cycle after a non-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Unmapped-access pulse |
| dev_irq | input | 32 | One request bit per device source |
| post_valid | output | 1 | Interrupt post strobe |
| post_cpu | output | 5 | Destination CPU of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
Acceptance of a request and a software write to the same source's control entry can land on the same clock edge. Both try to update the mask and pending bits.

The bench provokes this directly. It raises a source's request in the very cycle it writes that source's control entry with the pending-clear and mask-clear bits. It then reads the entry back and expects both mask and pending set. The random phase mixes sparse device requests with random control and routing writes, so these collisions also occur there. A bench model resolves each one the same way (acceptance wins).

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC  = 32,
  parameter int CPU_W = 5,
  parameter int VEC_W = 6,
  parameter int AW    = 11,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_err,
  input  logic [NSRC-1:0]  dev_irq,
  output logic             post_valid,
  output logic [CPU_W-1:0] post_cpu,
  output logic [VEC_W-1:0] post_vec
);
  localparam int IW = $clog2(NSRC);

  logic [CPU_W-1:0] cpu_q [NSRC];
  logic [VEC_W-1:0] vec_q [NSRC];
  logic [NSRC-1:0]  mask_q, pend_q, req_q;
  logic [IW-1:0]    post_src_q;

  logic [NSRC-1:0] live, gnt_vec;
  logic [IW-1:0]   gnt_idx;
  logic            gnt_any;

  assign live    = req_q | (dev_irq & ~mask_q);
  assign gnt_any = |live;
  assign gnt_vec = gnt_any ? (NSRC'(1) << gnt_idx) : '0;

  always_comb begin
    gnt_idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (live[i]) gnt_idx = IW'(i);
  end

  logic          ctl_sel, hit;
  logic [IW-1:0] idx;
  logic [DW-1:0] rd_mux;

  assign ctl_sel = bus_addr[AW-1];
  assign idx     = bus_addr[IW+2:3];
  assign hit     = (bus_addr[AW-2:IW+3] == '0) && (bus_addr[2:0] == 3'd0);
  assign rd_mux  = ctl_sel ? DW'({mask_q[idx], 1'b0, pend_q[idx]})
                           : ((DW'(cpu_q[idx]) << 8) | DW'(vec_q[idx]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '1;
      pend_q     <= '0;
      req_q      <= '0;
      for (int i = 0; i < NSRC; i++) begin
        cpu_q[i] <= '0;
        vec_q[i] <= '0;
      end
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
      post_src_q <= '0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
    end else begin
      bus_err   <= bus_sel & ~hit;
      bus_rdata <= (bus_sel && !bus_wr && hit) ? rd_mux : '0;
      if (bus_sel && bus_wr && hit) begin
        if (!ctl_sel) begin
          cpu_q[idx] <= bus_wdata[8 +: CPU_W];
          vec_q[idx] <= bus_wdata[VEC_W-1:0];
        end else begin
          mask_q[idx] <= bus_wdata[2];
          if (bus_wdata[1]) pend_q[idx] <= 1'b0;
        end
      end
      req_q      <= live & ~gnt_vec;
      post_valid <= gnt_any;
      if (gnt_any) begin
        mask_q[gnt_idx] <= 1'b1;
        pend_q[gnt_idx] <= 1'b1;
        post_cpu        <= cpu_q[gnt_idx];
        post_vec        <= vec_q[gnt_idx];
        post_src_q      <= gnt_idx;
      end
    end
  end

  // R6 R9
  acc_sets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> (mask_q[post_src_q] && pend_q[post_src_q]));

  // R7
  backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != '0) |-> post_valid);

  // R7
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != '0) |-> ((req_q & ((NSRC'(1) << post_src_q) | ((NSRC'(1) << post_src_q) - NSRC'(1)))) == '0));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));
endmodule

// File: tb/sim_irq_router.sv
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [31:0] dev_irq = '0;
  logic        post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;

  always #4 clk = ~clk;

  irq_router u0 (.clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
                 .bus_rdata, .bus_err, .dev_irq, .post_valid, .post_cpu, .post_vec);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] m_mask = '1, m_pend = '0, m_req = '0;
  logic [4:0]  m_cpu [32];
  logic [5:0]  m_vec [32];

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit w, input logic [10:0] a, input logic [31:0] d,
                     input logic [31:0] irq, input string tag);
    logic [31:0] live, e_rd;
    logic e_pv, e_err, hit, ctl;
    logic [4:0] e_cpu, idx;
    logic [5:0] e_vec;
    int g;
    live  = m_req | (irq & ~m_mask);
    g     = lowest(live);
    e_pv  = (live != 0);
    e_cpu = m_cpu[g];
    e_vec = m_vec[g];
    hit   = s && (a[9:8] == 2'b00) && (a[2:0] == 3'd0);
    ctl   = a[10];
    idx   = a[7:3];
    e_err = s && !hit;
    e_rd  = '0;
    if (hit && !w) e_rd = ctl ? {29'd0, m_mask[idx], 1'b0, m_pend[idx]}
                              : ({27'd0, m_cpu[idx]} << 8) | {26'd0, m_vec[idx]};
    if (hit && w) begin
      if (!ctl) begin m_cpu[idx] = d[12:8]; m_vec[idx] = d[5:0]; end
      else begin m_mask[idx] = d[2]; if (d[1]) m_pend[idx] = 1'b0; end
    end
    m_req = live;
    if (e_pv) begin
      m_mask[g] = 1'b1; m_pend[g] = 1'b1; m_req[g] = 1'b0;
    end
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; dev_irq = irq;
    @(posedge clk); #2;
    chk(tag, "post_valid", {31'd0, post_valid}, {31'd0, e_pv});
    if (e_pv) begin
      chk(tag, "post_cpu", {27'd0, post_cpu}, {27'd0, e_cpu});
      chk(tag, "post_vec", {26'd0, post_vec}, {26'd0, e_vec});
    end
    chk(tag, "bus_err", {31'd0, bus_err}, {31'd0, e_err});
    if (s && !w) chk(tag, "bus_rdata", bus_rdata, e_rd);
    @(negedge clk);
    bus_sel = 1'b0; dev_irq = '0;
  endtask

  task automatic idle(input string tag); cyc(0, 0, '0, '0, '0, tag); endtask
  function automatic logic [10:0] ra(input int i); return 11'(i * 8); endfunction
  function automatic logic [10:0] ca(input int i); return 11'(12'h400 + i * 8); endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < 32; i++) begin m_cpu[i] = '0; m_vec[i] = '0; end
    seed = 7;
    void'($urandom(seed));
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post_valid", {31'd0, post_valid}, 32'd0);
    chk("R1", "bus_err", {31'd0, bus_err}, 32'd0);
    chk("R1", "bus_rdata", bus_rdata, 32'd0);
    cyc(1, 0, ca(0), '0, '0, "R1");
    cyc(1, 0, ca(31), '0, '0, "R1");
    cyc(1, 0, ra(17), '0, '0, "R1");
    // R2 routing write/readback
    cyc(1, 1, ra(5), 32'hFFFF_FFFF, '0, "R2");
    cyc(1, 0, ra(5), '0, '0, "R2");
    cyc(1, 1, ra(6), 32'h0000_152A, '0, "R2");
    cyc(1, 0, ra(6), '0, '0, "R2");
    // R5 masked source dropped
    cyc(0, 0, '0, '0, 32'h0000_0020, "R5");
    idle("R5");
    cyc(1, 0, ca(5), '0, '0, "R5");
    // R3 unmask and read
    cyc(1, 1, ca(5), 32'hFFFF_FFF8 & ~32'h4 | 32'h0, '0, "R3");
    cyc(1, 0, ca(5), '0, '0, "R3");
    // R6 accept
    cyc(0, 0, '0, '0, 32'h0000_0020, "R6");
    idle("R6");
    cyc(1, 0, ca(5), '0, '0, "R6");
    cyc(0, 0, '0, '0, 32'h0000_0020, "R6");
    // R4 pend clear semantics
    cyc(1, 1, ca(5), 32'h0, '0, "R4");
    cyc(1, 0, ca(5), '0, '0, "R4");
    cyc(1, 1, ca(5), 32'h6, '0, "R4");
    cyc(1, 0, ca(5), '0, '0, "R4");
    // R7 simultaneous sources
    cyc(1, 1, ra(2), 32'h0000_0203, '0, "R7");
    cyc(1, 1, ra(9), 32'h0000_0909, '0, "R7");
    cyc(1, 1, ca(2), 32'h0, '0, "R7");
    cyc(1, 1, ca(9), 32'h0, '0, "R7");
    cyc(1, 1, ca(31), 32'h0, '0, "R7");
    cyc(0, 0, '0, '0, 32'h8000_0204, "R7");
    idle("R7"); idle("R7"); idle("R7");
    // R8 unmapped
    cyc(1, 0, 11'h100, '0, '0, "R8");
    cyc(1, 0, ra(3) | 11'h4, '0, '0, "R8");
    cyc(1, 1, 11'h500, 32'hFFFF_FFFF, '0, "R8");
    cyc(1, 0, ca(0), '0, '0, "R8");
    // R9 acceptance vs same-cycle control write
    cyc(1, 1, ca(3), 32'h0, '0, "R9");
    cyc(1, 1, ca(3), 32'h2, 32'h0000_0008, "R9");
    cyc(1, 0, ca(3), '0, '0, "R9");
    // R10 rdata zero after non-read
    cyc(1, 1, ra(4), 32'h1F3F, '0, "R10");
    chk("R10", "bus_rdata", bus_rdata, 32'd0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r, i;
      logic [10:0] a;
      logic [31:0] irq;
      r = $urandom % 16;
      i = $urandom % 32;
      irq = $urandom & $urandom & $urandom & $urandom;
      case (r)
        0, 1:    a = ca(i);
        2:       a = ra(i);
        3:       a = 11'($urandom);
        default: a = ca(i);
      endcase
      if (r < 4) cyc(1, ($urandom % 2) == 1, a, $urandom, irq, "R6 R7 R9");
      else if (r < 7) cyc(1, 1, ca(i), 32'h0, irq, "R6 R7 R9");
      else cyc(0, 0, '0, '0, irq, "R5 R6 R7");
    end
    for (int i = 0; i < 40; i++) idle("R7");
    for (int i = 0; i < 32; i++) cyc(1, 0, ca(i), '0, '0, "R3");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule